// File: doc/BRIEF.md
# Packed Halfword Saturating Cross Add-Subtract Unit

This datapath unit takes two 32-bit operands, each holding two signed 16-bit halfwords, and forms two results at once by crossing the halves. The upper half of the first operand is paired with the lower half of the second operand. The lower half of the first operand is paired with the upper half of the second operand. One pairing is added and the other is subtracted. A one-bit operation select decides which pairing gets the sum and which gets the difference.

Each lane computes its result one bit wider than the halfword. It then clamps the result to the signed 16-bit range, so a wrapped value never leaves the unit. A valid-in strobe loads the operands. The packed result appears one clock later from a single output register, together with valid-out. The unit reads and writes no condition or status flags.

The lane width is a parameter, set to 16 by default. The unit is built for issue slots in a wider execution pipeline that already own decode, operand fetch and writeback.

Top module: `hw_cross_qaddsub`

## Requirements
- R1: With op_sel = 0, result[31:16] is the clamped sum of src_a[31:16] and src_b[15:0], with all values read as signed.
- R2: With op_sel = 0, result[15:0] is the clamped difference src_a[15:0] minus src_b[31:16].
- R3: With op_sel = 1, result[31:16] is the clamped difference src_a[31:16] minus src_b[15:0].
- R4: With op_sel = 1, result[15:0] is the clamped sum of src_a[15:0] and src_b[31:16].
- R5: A lane whose exact result is above 32767 outputs 16'h7FFF.
- R6: A lane whose exact result is below -32768 outputs 16'h8000.
- R7: When valid_in is high at a rising edge, valid_out is high after that edge and result carries that operation's value, with the upper lane in bits 31:16.
- R8: When valid_in is low at a rising edge, valid_out is low after that edge and result keeps its previous value. op_sel, src_a and src_b are ignored in that cycle.
- R9: A synchronous active-high rst clears both valid_out and result to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and op_sel are loaded when high |
| op_sel | input | 1 | 0: upper lane adds and lower lane subtracts; 1: upper lane subtracts and lower lane adds |
| src_a | input | 32 | First operand, two signed halfwords |
| src_b | input | 32 | Second operand, two signed halfwords |
| valid_out | output | 1 | High for one cycle after each loaded operation |
| result | output | 32 | Packed clamped results; upper lane in bits 31:16 |

## Verification
A lane wired to the wrong half, or given the wrong add/subtract sense, shows up as a wrong halfword in the first result that follows. A clamp that picks the wrong bound, or that never fires, shows up only when the operands overflow. For this reason the operand stream mixes the extreme values 16'h7FFF, 16'h8000 and 16'hFFFF with fully random halfwords. A result register that loads while idle, or a valid bit that leaks, differs from the reference in the very next cycle. The result and valid_out are compared against a behavioural model on every clock.

// File: rtl/xsat_pkg.sv
package xsat_pkg;
   // Operation select encoding
   typedef enum logic {
      XS_ADD_SUB = 1'b0,   // upper lane adds, lower lane subtracts
      XS_SUB_ADD = 1'b1    // upper lane subtracts, lower lane adds
   } xs_op_e;

   localparam int unsigned XS_LANES = 2;
endpackage

// File: rtl/xsat_lane.sv
module xsat_lane #(
   parameter int unsigned LANE_W = 16
) (
   input  logic [LANE_W-1:0] lhs,
   input  logic [LANE_W-1:0] rhs,
   input  logic              do_sub,
   output logic [LANE_W-1:0] lane_out
);
   localparam int unsigned WIDE_W = LANE_W + 1;

   logic [WIDE_W-1:0] lhs_x, rhs_x, acc;
   logic              wrapped;

   always_comb begin
      lhs_x   = {lhs[LANE_W-1], lhs};
      rhs_x   = {rhs[LANE_W-1], rhs};
      acc     = do_sub ? (lhs_x - rhs_x) : (lhs_x + rhs_x);
      // The two top bits disagree exactly when the value leaves the lane range
      wrapped = acc[WIDE_W-1] ^ acc[WIDE_W-2];
      if (wrapped)
         lane_out = {acc[WIDE_W-1], {(LANE_W-1){~acc[WIDE_W-1]}}};
      else
         lane_out = acc[LANE_W-1:0];
   end
endmodule

// File: rtl/xsat_stage.sv
module xsat_stage #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic              vld_q,
   output logic [DATA_W-1:0] dout_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= 1'b0;
         dout_q <= '0;
      end else begin
         vld_q <= load;
         if (load) dout_q <= din;
      end
   end
endmodule

// File: rtl/hw_cross_qaddsub.sv
module hw_cross_qaddsub
   import xsat_pkg::*;
#(
   parameter int unsigned LANE_W = 16,
   localparam int unsigned WORD_W = LANE_W * XS_LANES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_in,
   input  logic              op_sel,
   input  logic [WORD_W-1:0] src_a,
   input  logic [WORD_W-1:0] src_b,
   output logic              valid_out,
   output logic [WORD_W-1:0] result
);
   if (LANE_W < 2) begin : g_bad_width
      $error("hw_cross_qaddsub: LANE_W must be at least 2");
   end

   xs_op_e             op_kind;
   logic [WORD_W-1:0]  next_word;

   assign op_kind = xs_op_e'(op_sel);

   // Lane g takes half g of src_a and the opposite half of src_b.
   // Lane 1 (upper) subtracts in XS_SUB_ADD; lane 0 (lower) subtracts in XS_ADD_SUB.
   for (genvar g = 0; g < XS_LANES; g++) begin : g_lane
      localparam int unsigned PARTNER = XS_LANES - 1 - g;
      logic sub_here;
      if (g == 0) begin : g_low
         assign sub_here = (op_kind == XS_ADD_SUB);
      end else begin : g_high
         assign sub_here = (op_kind == XS_SUB_ADD);
      end
      xsat_lane #(.LANE_W(LANE_W)) u_lane (
         .lhs      (src_a[g*LANE_W +: LANE_W]),
         .rhs      (src_b[PARTNER*LANE_W +: LANE_W]),
         .do_sub   (sub_here),
         .lane_out (next_word[g*LANE_W +: LANE_W])
      );
   end

   xsat_stage #(.DATA_W(WORD_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .load   (valid_in),
      .din    (next_word),
      .vld_q  (valid_out),
      .dout_q (result)
   );
endmodule

// File: rtl/xsat_chk.sv
module xsat_chk #(
   parameter int unsigned LANE_W = 16,
   localparam int unsigned WORD_W = LANE_W * 2
) (
   input logic              clk,
   input logic              rst,
   input logic              valid_in,
   input logic              op_sel,
   input logic [WORD_W-1:0] src_a,
   input logic [WORD_W-1:0] src_b,
   input logic              valid_out,
   input logic [WORD_W-1:0] result
);
   function automatic logic [LANE_W-1:0] clamp_ref(input logic [LANE_W-1:0] x,
                                                   input logic [LANE_W-1:0] y,
                                                   input logic sub);
      longint xv, yv, r, hi, lo;
      xv = longint'($signed(x));
      yv = longint'($signed(y));
      r  = sub ? xv - yv : xv + yv;
      hi = (longint'(1) <<< (LANE_W - 1)) - 1;
      lo = -(longint'(1) <<< (LANE_W - 1));
      if (r > hi) r = hi;
      if (r < lo) r = lo;
      return r[LANE_W-1:0];
   endfunction

   logic [LANE_W-1:0] a_hi, a_lo, b_hi, b_lo, q_hi, q_lo;
   assign a_hi = src_a[WORD_W-1:LANE_W];
   assign a_lo = src_a[LANE_W-1:0];
   assign b_hi = src_b[WORD_W-1:LANE_W];
   assign b_lo = src_b[LANE_W-1:0];
   assign q_hi = result[WORD_W-1:LANE_W];
   assign q_lo = result[LANE_W-1:0];

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (!valid_out && result == '0));

   assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> (!valid_out && $stable(result)));

   assert_upper_add_R1: assert property (@(posedge clk) disable iff (rst)
      (valid_in && !op_sel) |=> q_hi == $past(clamp_ref(a_hi, b_lo, 1'b0)));

   assert_lower_sub_R2: assert property (@(posedge clk) disable iff (rst)
      (valid_in && !op_sel) |=> q_lo == $past(clamp_ref(a_lo, b_hi, 1'b1)));

   assert_upper_sub_R3: assert property (@(posedge clk) disable iff (rst)
      (valid_in && op_sel) |=> q_hi == $past(clamp_ref(a_hi, b_lo, 1'b1)));

   assert_lower_add_R4: assert property (@(posedge clk) disable iff (rst)
      (valid_in && op_sel) |=> q_lo == $past(clamp_ref(a_lo, b_hi, 1'b0)));
endmodule

bind hw_cross_qaddsub xsat_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/hw_cross_qaddsub_bench.sv
module hw_cross_qaddsub_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_in = 1'b0;
   logic        op_sel = 1'b0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic        valid_out;
   logic [31:0] result;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   hw_cross_qaddsub u_hw_cross_qaddsub (
      .clk(clk), .rst(rst), .valid_in(valid_in), .op_sel(op_sel),
      .src_a(src_a), .src_b(src_b), .valid_out(valid_out), .result(result)
   );

   // ---------------- reference model ----------------
   bit          m_v = 1'b0;
   logic [31:0] m_r = '0;
   bit          m_rst = 1'b0;
   bit          m_live = 1'b0;
   string       tag_hi = "R9", tag_lo = "R9";

   function automatic int clamp16(input int v, output string sat);
      sat = "";
      if (v > 32767)  begin sat = "R5"; return 32767; end
      if (v < -32768) begin sat = "R6"; return -32768; end
      return v;
   endfunction

   always @(posedge clk) begin
      int    hi, lo;
      string s1, s2;
      m_live = 1'b1;
      if (rst) begin
         m_v = 0; m_r = '0; m_rst = 1;
      end else begin
         m_rst = 0;
         m_v   = valid_in;
         if (valid_in) begin
            if (!op_sel) begin
               hi = clamp16(int'($signed(src_a[31:16])) + int'($signed(src_b[15:0])), s1);
               lo = clamp16(int'($signed(src_a[15:0])) - int'($signed(src_b[31:16])), s2);
               tag_hi = (s1 != "") ? {"R1/", s1} : "R1";
               tag_lo = (s2 != "") ? {"R2/", s2} : "R2";
            end else begin
               hi = clamp16(int'($signed(src_a[31:16])) - int'($signed(src_b[15:0])), s1);
               lo = clamp16(int'($signed(src_a[15:0])) + int'($signed(src_b[31:16])), s2);
               tag_hi = (s1 != "") ? {"R3/", s1} : "R3";
               tag_lo = (s2 != "") ? {"R4/", s2} : "R4";
            end
            m_r = {hi[15:0], lo[15:0]};
         end
      end
   end

   // ---------------- compare away from the active edge ----------------
   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (m_live) begin
         if (m_rst) begin
            check("R9 valid_out", {31'd0, valid_out}, 32'd0);
            check("R9 result", result, 32'd0);
         end else if (m_v) begin
            check("R7 valid_out", {31'd0, valid_out}, 32'd1);
            check(tag_hi, {16'd0, result[31:16]}, {16'd0, m_r[31:16]});
            check(tag_lo, {16'd0, result[15:0]}, {16'd0, m_r[15:0]});
         end else begin
            check("R8 valid_out", {31'd0, valid_out}, 32'd0);
            check("R8 result held", result, m_r);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input bit v, input bit op, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      valid_in = v; op_sel = op; src_a = a; src_b = b;
   endtask

   function automatic logic [15:0] pick_half();
      case ($urandom_range(0, 7))
         0: return 16'h7FFF;
         1: return 16'h8000;
         2: return 16'hFFFF;
         3: return 16'h0000;
         4: return 16'h0001;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R5: 0x7FFF + 0x7FFF on the upper lane, add-subtract form
      drive(1, 0, 32'h7FFF_0000, 32'h0000_7FFF);
      // R6: 0x8000 - 0x7FFF on the lower lane, add-subtract form
      drive(1, 0, 32'h0000_8000, 32'h7FFF_0000);
      // R6: 0x8000 + 0x8000 on the lower lane, subtract-add form
      drive(1, 1, 32'h0000_8000, 32'h8000_0000);
      // R5: 0x7FFF - 0x8000 on the upper lane, subtract-add form
      drive(1, 1, 32'h7FFF_0000, 32'h0000_8000);
      // exact bounds reached without clamping
      drive(1, 0, 32'h7FFE_8001, 32'h0001_0001);
      drive(1, 1, 32'h8001_7FFE, 32'h0001_0001);
      // R8: idle cycles with changing operands must not disturb the result
      drive(0, 1, 32'h1234_5678, 32'h9ABC_DEF0);
      drive(0, 0, 32'hFFFF_FFFF, 32'h8000_8000);
      drive(1, 0, 32'h0010_0020, 32'h0003_0004);
      // R9: reset in the middle of traffic
      drive(1, 1, 32'h4000_4000, 32'h4000_4000);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0; valid_in = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         drive($urandom_range(0, 3) != 0, 1'($urandom),
               {pick_half(), pick_half()}, {pick_half(), pick_half()});
      end
      drive(0, 0, '0, '0);
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule